// File: doc/BRIEF.md
# Windowed Pixel-Array Readout Sequencer

This block sequences the readout of a CMOS active-pixel array whose rows and columns are addressed like a memory. After a start request it visits each row of a programmable rectangular window in turn. Each visited row goes through the same phases: the pixels of the row are reset, a programmable integration interval elapses, the row is selected so its pixels drive the column amplifiers, a strobe captures the amplifier outputs into the readout register, and the captured columns of the window are then stepped out one per clock.

The window bounds and the integration length are captured at the moment a frame is accepted. A window whose bounds are inverted or lie outside the array is refused with a one-cycle error pulse, and no pixel is touched. When the last column of the last row has been presented, a one-cycle completion pulse is raised and the sequencer returns to idle. The analog pixel, the column amplifiers and the converter are outside this block.

Top module: `pix_win_readout`

## Requirements
- R1: While reset is asserted, and in idle afterwards, busy, pix_rst, row_sel, col_latch, pix_valid, frame_done and frame_err are all low, and row_addr and col_addr are zero after reset.
- R2: A start pulse sampled in idle captures row_lo, row_hi, col_lo, col_hi and integ_len; changes to those inputs during a frame have no effect on the rows, columns or timing of that frame.
- R3: Rows are visited in ascending order from row_lo to row_hi inclusive; for each, pix_rst is high for exactly RST_CYC consecutive cycles with row_addr equal to that row.
- R4: After pix_rst falls, the integration phase lasts integ_len + 1 cycles (integ_len as captured, 0 giving one cycle), and row_sel rises on the next cycle.
- R5: For each row, row_sel is high for exactly two consecutive cycles, and col_latch is high only in the second of them; col_latch is never high without row_sel.
- R6: After the strobe, pix_valid is high for one cycle per column, col_addr runs from col_lo to col_hi inclusive, one step per clock, with row_addr held and row_sel and pix_rst low.
- R7: frame_done is high for exactly one cycle, the cycle immediately after the last pixel of the last window row; busy is low in the cycle after frame_done.
- R8: If at start row_lo > row_hi, col_lo > col_hi, row_hi >= ROWS or col_hi >= COLS, frame_err is high for one cycle in the cycle after start, no pix_rst or pix_valid follows, and the block is idle in the cycle after that.
- R9: A start pulse while busy is high is ignored: the running frame continues unchanged and no further frame follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Frame request, sampled in idle |
| row_lo | input | RW | First window row |
| row_hi | input | RW | Last window row (inclusive) |
| col_lo | input | CW | First window column |
| col_hi | input | CW | Last window column (inclusive) |
| integ_len | input | INT_W | Integration length minus one, in clocks |
| busy | output | 1 | A frame or an error report is in progress |
| row_addr | output | RW | Address of the row being processed |
| row_sel | output | 1 | Row drives the column amplifiers |
| pix_rst | output | 1 | Reset of the addressed row's pixels |
| col_latch | output | 1 | Capture strobe for the readout register |
| col_addr | output | CW | Column being presented |
| pix_valid | output | 1 | A pixel of the window is presented this cycle |
| frame_done | output | 1 | One-cycle pulse after the last pixel |
| frame_err | output | 1 | One-cycle pulse for a refused window |

## Verification
The bench builds the block with a 12-row by 10-column array, an 8-bit integration field and a three-cycle reset phase. Because neither dimension is a power of two, bounds that fit in the address width but lie past the array edge are reachable, so the range rejection can be exercised alongside inverted windows. The small array lets a full-frame read, a sub-window with the shortest integration, a single-pixel window at the far corner, and frames disturbed by input changes and repeated start requests all run within a few thousand cycles.

// File: rtl/pwr_pkg.sv
package pwr_pkg;

   typedef enum logic [2:0] {
      PS_IDLE  = 3'd0,
      PS_RST   = 3'd1,
      PS_INTEG = 3'd2,
      PS_SEL   = 3'd3,
      PS_LATCH = 3'd4,
      PS_SCAN  = 3'd5,
      PS_DONE  = 3'd6,
      PS_ERR   = 3'd7
   } pwr_state_e;

endpackage

// File: rtl/pwr_win_reg.sv
module pwr_win_reg #(
   parameter int ROWS  = 480,
   parameter int COLS  = 640,
   parameter int INT_W = 24,
   localparam int RW   = $clog2(ROWS),
   localparam int CW   = $clog2(COLS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [RW-1:0]    row_lo,
   input  logic [RW-1:0]    row_hi,
   input  logic [CW-1:0]    col_lo,
   input  logic [CW-1:0]    col_hi,
   input  logic [INT_W-1:0] integ_in,
   output logic [RW-1:0]    row_hi_q,
   output logic [CW-1:0]    col_lo_q,
   output logic [CW-1:0]    col_hi_q,
   output logic [INT_W-1:0] integ_q,
   output logic             win_ok
);

   logic rows_fit;
   logic cols_fit;

   // A dimension that fills its address width cannot be overrun.
   if ((1 << RW) == ROWS) begin : g_row_full
      assign rows_fit = 1'b1;
   end else begin : g_row_part
      assign rows_fit = (row_hi < RW'(ROWS));
   end

   if ((1 << CW) == COLS) begin : g_col_full
      assign cols_fit = 1'b1;
   end else begin : g_col_part
      assign cols_fit = (col_hi < CW'(COLS));
   end

   assign win_ok = rows_fit && cols_fit && (row_lo <= row_hi) && (col_lo <= col_hi);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         row_hi_q <= '0;
         col_lo_q <= '0;
         col_hi_q <= '0;
         integ_q  <= '0;
      end else if (load) begin
         row_hi_q <= row_hi;
         col_lo_q <= col_lo;
         col_hi_q <= col_hi;
         integ_q  <= integ_in;
      end
   end

   // R2: captured bounds move only on a load
   p_hold_unless_load_r2 : assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> $stable(row_hi_q) && $stable(col_lo_q) && $stable(col_hi_q) && $stable(integ_q));

endmodule

// File: rtl/pwr_axis_cnt.sv
module pwr_axis_cnt #(
   parameter int W = 9
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] base,
   input  logic         step,
   input  logic [W-1:0] hi,
   output logic [W-1:0] idx,
   output logic         last
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         idx <= '0;
      end else if (load) begin
         idx <= base;
      end else if (step) begin
         idx <= idx + W'(1);
      end
   end

   assign last = (idx == hi);

   // R3/R6: the sequencer never advances an index past its inclusive end
   p_no_step_past_end_r3 : assert property (@(posedge clk) disable iff (!rst_n)
      (step && !load) |-> !last);

endmodule

// File: rtl/pwr_phase_timer.sv
module pwr_phase_timer #(
   parameter int W = 24
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   output logic         expired
);

   logic [W-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (load) begin
         cnt <= load_val;
      end else if (cnt != '0) begin
         cnt <= cnt - W'(1);
      end
   end

   assign expired = (cnt == '0);

   // R4: once expired the timer stays at zero until reloaded
   p_rest_at_zero_r4 : assert property (@(posedge clk) disable iff (!rst_n)
      (!load && expired) |=> expired);

endmodule

// File: rtl/pix_win_readout.sv
module pix_win_readout
   import pwr_pkg::*;
#(
   parameter int ROWS    = 480,
   parameter int COLS    = 640,
   parameter int INT_W   = 24,
   parameter int RST_CYC = 4,
   localparam int RW     = $clog2(ROWS),
   localparam int CW     = $clog2(COLS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [RW-1:0]    row_lo,
   input  logic [RW-1:0]    row_hi,
   input  logic [CW-1:0]    col_lo,
   input  logic [CW-1:0]    col_hi,
   input  logic [INT_W-1:0] integ_len,
   output logic             busy,
   output logic [RW-1:0]    row_addr,
   output logic             row_sel,
   output logic             pix_rst,
   output logic             col_latch,
   output logic [CW-1:0]    col_addr,
   output logic             pix_valid,
   output logic             frame_done,
   output logic             frame_err
);

   // elaboration-time parameter checks
   if (ROWS < 2 || COLS < 2) begin : g_bad_dims
      $error("pix_win_readout: ROWS and COLS must be at least 2");
   end
   if (INT_W < 1 || INT_W > 30) begin : g_bad_intw
      $error("pix_win_readout: INT_W must lie in 1..30");
   end
   if (RST_CYC < 1 || RST_CYC > (1 << INT_W)) begin : g_bad_rst
      $error("pix_win_readout: RST_CYC must lie in 1..2**INT_W");
   end

   localparam logic [INT_W-1:0] RST_LOAD = INT_W'(RST_CYC - 1);

   pwr_state_e       st_q, st_d;
   logic [RW-1:0]    row_hi_q, row_idx;
   logic [CW-1:0]    col_lo_q, col_hi_q, col_idx;
   logic [INT_W-1:0] integ_q, t_val;
   logic             win_ok, accept;
   logic             row_last, col_last, t_exp;
   logic             t_load, row_load, row_step, col_load, col_step;

   assign accept = (st_q == PS_IDLE) && start;

   pwr_win_reg #(.ROWS(ROWS), .COLS(COLS), .INT_W(INT_W)) u_win (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (accept),
      .row_lo   (row_lo),
      .row_hi   (row_hi),
      .col_lo   (col_lo),
      .col_hi   (col_hi),
      .integ_in (integ_len),
      .row_hi_q (row_hi_q),
      .col_lo_q (col_lo_q),
      .col_hi_q (col_hi_q),
      .integ_q  (integ_q),
      .win_ok   (win_ok)
   );

   pwr_axis_cnt #(.W(RW)) u_row (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (row_load),
      .base  (row_lo),
      .step  (row_step),
      .hi    (row_hi_q),
      .idx   (row_idx),
      .last  (row_last)
   );

   pwr_axis_cnt #(.W(CW)) u_col (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (col_load),
      .base  (col_lo_q),
      .step  (col_step),
      .hi    (col_hi_q),
      .idx   (col_idx),
      .last  (col_last)
   );

   pwr_phase_timer #(.W(INT_W)) u_tmr (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (t_load),
      .load_val (t_val),
      .expired  (t_exp)
   );

   always_comb begin
      st_d     = st_q;
      t_load   = 1'b0;
      t_val    = RST_LOAD;
      row_load = 1'b0;
      row_step = 1'b0;
      col_load = 1'b0;
      col_step = 1'b0;
      case (st_q)
         PS_IDLE: begin
            if (start) begin
               if (win_ok) begin
                  st_d     = PS_RST;
                  row_load = 1'b1;
                  t_load   = 1'b1;
               end else begin
                  st_d = PS_ERR;
               end
            end
         end
         PS_RST: begin
            if (t_exp) begin
               st_d   = PS_INTEG;
               t_load = 1'b1;
               t_val  = integ_q;
            end
         end
         PS_INTEG: begin
            if (t_exp) st_d = PS_SEL;
         end
         PS_SEL: begin
            st_d     = PS_LATCH;
            col_load = 1'b1;
         end
         PS_LATCH: begin
            st_d = PS_SCAN;
         end
         PS_SCAN: begin
            if (col_last) begin
               if (row_last) begin
                  st_d = PS_DONE;
               end else begin
                  st_d     = PS_RST;
                  row_step = 1'b1;
                  t_load   = 1'b1;
               end
            end else begin
               col_step = 1'b1;
            end
         end
         default: st_d = PS_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) st_q <= PS_IDLE;
      else        st_q <= st_d;
   end

   assign busy       = (st_q != PS_IDLE);
   assign row_addr   = row_idx;
   assign col_addr   = col_idx;
   assign pix_rst    = (st_q == PS_RST);
   assign row_sel    = (st_q == PS_SEL) || (st_q == PS_LATCH);
   assign col_latch  = (st_q == PS_LATCH);
   assign pix_valid  = (st_q == PS_SCAN);
   assign frame_done = (st_q == PS_DONE);
   assign frame_err  = (st_q == PS_ERR);

   // R1: nothing drives the array while idle
   p_idle_quiet_r1 : assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !(pix_rst || row_sel || col_latch || pix_valid || frame_done || frame_err));

   // R2: captured window stays fixed throughout a frame
   p_bounds_frozen_r2 : assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> $stable(row_hi_q) && $stable(col_lo_q) && $stable(col_hi_q) && $stable(integ_q));

   // R5: strobe only while the row is selected, after a select-only cycle
   p_latch_needs_sel_r5 : assert property (@(posedge clk) disable iff (!rst_n)
      col_latch |-> row_sel);
   p_latch_after_sel_r5 : assert property (@(posedge clk) disable iff (!rst_n)
      col_latch |-> $past(row_sel) && !$past(col_latch));

   // R6: column scan is quiet on the row controls and steps by one
   p_scan_quiet_r6 : assert property (@(posedge clk) disable iff (!rst_n)
      pix_valid |-> !row_sel && !pix_rst && !col_latch);
   p_col_step_r6 : assert property (@(posedge clk) disable iff (!rst_n)
      (pix_valid && $past(pix_valid)) |-> (col_addr == $past(col_addr) + CW'(1)) &&
                                          (row_addr == $past(row_addr)));

   // R7: completion is a single pulse followed by idle
   p_done_pulse_r7 : assert property (@(posedge clk) disable iff (!rst_n)
      frame_done |=> !frame_done && !busy);

   // R8: error report is a single pulse followed by idle
   p_err_pulse_r8 : assert property (@(posedge clk) disable iff (!rst_n)
      frame_err |=> !frame_err && !busy);

endmodule

// File: tb/pix_win_readout_bench.sv
module pix_win_readout_bench;

   localparam int ROWS    = 12;
   localparam int COLS    = 10;
   localparam int INT_W   = 8;
   localparam int RST_CYC = 3;
   localparam int RW      = $clog2(ROWS);
   localparam int CW      = $clog2(COLS);

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic             rst_n, start;
   logic [RW-1:0]    row_lo, row_hi, row_addr;
   logic [CW-1:0]    col_lo, col_hi, col_addr;
   logic [INT_W-1:0] integ_len;
   logic             busy, row_sel, pix_rst, col_latch, pix_valid, frame_done, frame_err;

   pix_win_readout #(.ROWS(ROWS), .COLS(COLS), .INT_W(INT_W), .RST_CYC(RST_CYC)) u_pix_win_readout (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start),
      .row_lo     (row_lo),
      .row_hi     (row_hi),
      .col_lo     (col_lo),
      .col_hi     (col_hi),
      .integ_len  (integ_len),
      .busy       (busy),
      .row_addr   (row_addr),
      .row_sel    (row_sel),
      .pix_rst    (pix_rst),
      .col_latch  (col_latch),
      .col_addr   (col_addr),
      .pix_valid  (pix_valid),
      .frame_done (frame_done),
      .frame_err  (frame_err)
   );

   int n_chk  = 0;
   int n_fail = 0;

   task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // scoreboard queues filled by the driver, drained by the monitor
   int pix_q[$];
   int row_q[$];
   int exp_int   = 0;
   int done_cnt  = 0;
   int err_cnt   = 0;
   int act_cnt   = 0;
   bit mon_on    = 1'b0;

   bit prev_rst = 0, prev_sel = 0, prev_valid = 0, in_gap = 0, after_done = 0;
   int rst_run = 0, gap_run = 0, sel_run = 0, latch_pos = 0;

   always @(negedge clk) begin
      if (mon_on) begin
         if (after_done) begin
            chk(!busy && !frame_done, "R7", "busy or done in cycle after done", int'(busy) + int'(frame_done), 0);
            after_done = 0;
         end
         if (pix_rst || pix_valid) act_cnt++;
         if (pix_rst) rst_run++;
         if (prev_rst && !pix_rst) begin
            chk(rst_run == RST_CYC, "R3", "reset phase length", rst_run, RST_CYC);
            if (row_q.size() == 0) begin
               chk(0, "R3", "row not expected", int'(row_addr), -1);
            end else begin
               int er;
               er = row_q.pop_front();
               chk(int'(row_addr) == er, "R3", "reset row address", int'(row_addr), er);
            end
            rst_run = 0;
            in_gap  = 1;
            gap_run = 0;
         end
         if (in_gap) begin
            if (row_sel) begin
               chk(gap_run == exp_int + 1, "R4", "integration length", gap_run, exp_int + 1);
               in_gap = 0;
            end else begin
               gap_run++;
            end
         end
         if (row_sel) begin
            sel_run++;
            if (col_latch) latch_pos = sel_run;
         end
         if (col_latch && !row_sel) chk(0, "R5", "strobe without select", 1, 0);
         if (prev_sel && !row_sel) begin
            chk(sel_run == 2 && latch_pos == 2, "R5", "select length*10+strobe slot",
                sel_run * 10 + latch_pos, 22);
            sel_run   = 0;
            latch_pos = 0;
         end
         if (pix_valid) begin
            int got;
            got = int'(row_addr) * 256 + int'(col_addr);
            if (pix_q.size() == 0) begin
               chk(0, "R6", "pixel not expected", got, -1);
            end else begin
               int ep;
               ep = pix_q.pop_front();
               chk(got == ep, "R6", "pixel row*256+col", got, ep);
            end
         end
         if (frame_done) begin
            done_cnt++;
            chk(prev_valid && pix_q.size() == 0, "R7", "pixels left when done",
                pix_q.size() + (prev_valid ? 0 : 1000), 0);
            after_done = 1;
         end
         if (frame_err) err_cnt++;
         prev_rst   = pix_rst;
         prev_sel   = row_sel;
         prev_valid = pix_valid;
      end
   end

   task automatic set_win(input int rl, input int rh, input int cl, input int ch, input int il);
      row_lo    = RW'(rl);
      row_hi    = RW'(rh);
      col_lo    = CW'(cl);
      col_hi    = CW'(ch);
      integ_len = INT_W'(il);
   endtask

   task automatic pulse_start();
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic run_frame(input int rl, input int rh, input int cl, input int ch, input int il,
                            input bit disturb);
      int d, e;
      for (int r = rl; r <= rh; r++) begin
         row_q.push_back(r);
         for (int c = cl; c <= ch; c++) pix_q.push_back(r * 256 + c);
      end
      exp_int = il;
      d = done_cnt;
      e = err_cnt;
      set_win(rl, rh, cl, ch, il);
      pulse_start();
      if (disturb) begin
         // R2/R9: new bounds and a second start while the frame runs
         repeat (2) @(negedge clk);
         set_win(0, ROWS - 1, 0, COLS - 1, 9);
         pulse_start();
         repeat (20) @(negedge clk);
         pulse_start();
      end
      while (done_cnt == d) @(negedge clk);
      repeat (3) @(negedge clk);
      chk(pix_q.size() == 0 && row_q.size() == 0, "R2", "items left after frame",
          pix_q.size() + row_q.size(), 0);
      chk(done_cnt == d + 1, "R9", "completion count", done_cnt - d, 1);
      chk(err_cnt == e, "R8", "error on valid window", err_cnt - e, 0);
      chk(!busy, "R9", "busy after frame", int'(busy), 0);
   endtask

   task automatic run_bad(input int rl, input int rh, input int cl, input int ch, input string what);
      int a, e;
      a = act_cnt;
      e = err_cnt;
      set_win(rl, rh, cl, ch, 2);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk(frame_err, {"R8 ", what}, "error pulse cycle after start", int'(frame_err), 1);
      repeat (3) @(negedge clk);
      chk(err_cnt == e + 1, {"R8 ", what}, "error pulses", err_cnt - e, 1);
      chk(act_cnt == a, {"R8 ", what}, "array activity", act_cnt - a, 0);
      chk(!busy, {"R8 ", what}, "busy after error", int'(busy), 0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      rst_n = 1'b0;
      start = 1'b0;
      set_win(0, 0, 0, 0, 0);
      repeat (3) @(negedge clk);
      chk(!busy && !pix_rst && !row_sel && !col_latch && !pix_valid && !frame_done && !frame_err,
          "R1", "outputs in reset", int'(busy | pix_rst | row_sel | pix_valid), 0);
      chk(row_addr == '0 && col_addr == '0, "R1", "addresses in reset",
          int'(row_addr) + int'(col_addr), 0);
      rst_n = 1'b1;
      @(negedge clk);
      mon_on = 1'b1;
      repeat (2) @(negedge clk);
      chk(!busy && !pix_valid && !pix_rst, "R1", "idle after reset", int'(busy), 0);

      // R3 R4 R5 R6 R7: whole array
      run_frame(0, ROWS - 1, 0, COLS - 1, 5, 1'b0);
      // R4 shortest integration, sub-window, disturbed inputs (R2, R9)
      run_frame(3, 5, 2, 7, 0, 1'b1);
      // single pixel at the far corner
      run_frame(ROWS - 1, ROWS - 1, COLS - 1, COLS - 1, 1, 1'b0);
      // single column, tall window
      run_frame(1, 8, 4, 4, 3, 1'b0);

      // R8 refused windows
      run_bad(6, 4, 0, 3, "rows inverted");
      run_bad(0, 2, 7, 5, "cols inverted");
      run_bad(0, ROWS, 0, 3, "row past edge");
      run_bad(2, 2, 0, COLS + 2, "col past edge");

      // recovery after errors
      run_frame(7, 9, 0, 1, 2, 1'b0);

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule